// File: doc/BRIEF.md
# Cache-Aware Write Burst Splitter

This block takes one DMA write request, given as a starting byte address and a byte count, and cuts it into a series of bus write bursts. For each burst it picks a command. The invalidating write is used when the burst starts on a cache line boundary and covers whole lines. The plain memory write is used in every other case. Each burst leaves the block as a descriptor that carries a command code, a byte address and a byte length, under a valid/ready handshake.

The cache line size comes from an 8-bit setting that counts 32-bit words. A non-power-of-two or zero setting turns cache commands off. A bus master sits downstream and turns each descriptor into one bus ownership. The block does not model bus phases, arbitration or data movement.

Top module: `pci_wr_burst_splitter`

## Requirements
- R1: After reset `req_ready` is 1, and `desc_valid` and `done` are 0.
- R2: The line length in bytes is four times `req_cls`. Cache commands are enabled only when `req_cls` is a nonzero power of two. When they are disabled, the whole request leaves as one plain write descriptor with command code 4'b0111.
- R3: When the current address is not on a line boundary, the descriptor uses command 4'b0111. Its length runs up to the next line boundary, or to the end of the transfer if that comes first.
- R4: When the current address is on a line boundary and at least one whole line remains, the descriptor uses command 4'b1111. Its length is the largest multiple of the line length that does not exceed the remaining count.
- R5: When the current address is on a line boundary and less than one line remains, the remainder leaves as one 4'b0111 descriptor.
- R6: Descriptors come out in ascending, contiguous address order. The first starts at the request address, and their lengths add up to the requested count.
- R7: While `desc_valid` is 1 and `desc_ready` is 0, the descriptor command, address and length stay unchanged.
- R8: `done` is 1 for the cycle after the last descriptor is accepted, and `req_ready` is 1 in that same cycle. While descriptors are pending, `req_ready` is 0 and requests are ignored.
- R9: A request with a zero byte count produces no descriptor, and `done` is 1 in the cycle after acceptance.
- R10: `req_cls` is sampled when a request is accepted. Changing it during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_cls | input | CLS_W | Cache line size in 32-bit words |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Descriptor taken |
| desc_cmd | output | 4 | Bus command code |
| desc_addr | output | ADDR_W | Burst start byte address |
| desc_len | output | LEN_W | Burst length in bytes |
| done | output | 1 | Transfer complete pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by presenting the next request in the very cycle where `done` is high, in most sweeps. It then judges that the new request is taken at once and that its first descriptor follows on the next cycle. The sweep covers every address offset, byte count and line size in a small grid. During stalled cycles it also offers junk requests and changes the line size, to show that both are ignored.

// File: rtl/pci_wr_burst_splitter.sv
module pci_wr_burst_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CLS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CLS_W-1:0]  req_cls,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [3:0]        desc_cmd,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [LEN_W-1:0]  desc_len,
  output logic              done
);
  localparam int LB_W = CLS_W + 2;
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  logic              busy;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  rem;
  logic [LB_W-1:0]   lb;
  logic              cen;
  logic              done_q;

  wire cls_pow2 = (req_cls != '0) && ((req_cls & (req_cls - 1'b1)) == '0);
  wire accept   = req_valid && req_ready;
  wire take     = busy && desc_ready;

  wire [LB_W-1:0]  mask   = lb - 1'b1;
  wire [LB_W-1:0]  off    = cur[LB_W-1:0] & mask;
  wire [LEN_W-1:0] lb_l   = LEN_W'(lb);
  wire [LEN_W-1:0] to_bnd = lb_l - LEN_W'(off);
  wire [LEN_W-1:0] whole  = rem & ~LEN_W'(mask);

  assign req_ready  = !busy;
  assign desc_valid = busy;
  assign desc_addr  = cur;
  assign done       = done_q;

  always_comb begin
    desc_cmd = CMD_MW;
    desc_len = rem;
    if (cen) begin
      if (off != '0) begin
        desc_len = (rem < to_bnd) ? rem : to_bnd;
      end else if (rem >= lb_l) begin
        desc_cmd = CMD_MWI;
        desc_len = whole;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur    <= '0;
      rem    <= '0;
      lb     <= '0;
      cen    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cur <= req_addr;
        rem <= req_len;
        lb  <= {req_cls, 2'b00};
        cen <= cls_pow2;
        if (req_len == '0) done_q <= 1'b1;
        else               busy   <= 1'b1;
      end else if (take) begin
        cur <= cur + ADDR_W'(desc_len);
        rem <= rem - desc_len;
        if (desc_len == rem) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_mwi_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_cmd == CMD_MWI) |->
      ((desc_addr[LB_W-1:0] & mask) == '0) && ((desc_len & LEN_W'(mask)) == '0) && desc_len != '0);

  assert_desc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=>
      (desc_valid && $stable(desc_cmd) && $stable(desc_addr) && $stable(desc_len)));

  assert_len_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_len != '0 && desc_len <= rem));

  assert_no_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !req_ready);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!desc_valid && req_ready));

  assert_step_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && desc_len != rem) |=>
      (desc_valid && desc_addr == $past(desc_addr) + ADDR_W'($past(desc_len))));
endmodule

// File: tb/sim_pci_wr_burst_splitter.sv
module sim_pci_wr_burst_splitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int CLS_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [CLS_W-1:0]  req_cls = '0;
  logic desc_valid;
  logic desc_ready = 1'b0;
  logic [3:0] desc_cmd;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0] desc_len;
  logic done;

  int total = 0;
  int bad = 0;
  int xfers = 0;
  int steps = 0;

  always #5 clk = ~clk;

  pci_wr_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLS_W(CLS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_cls(req_cls),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
    .desc_addr(desc_addr), .desc_len(desc_len), .done(done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int cls, input int addr, input int len);
    int a = addr;
    int r = len;
    int sum = 0;
    int lb = cls * 4;
    bit en = (cls != 0) && ((cls & (cls - 1)) == 0);
    chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    req_cls   = CLS_W'(cls);
    @(negedge clk);
    req_valid = 1'b0;
    req_cls   = CLS_W'(cls + 3);
    if (len == 0) begin
      chk(done == 1'b1 && desc_valid == 1'b0, "R9 zero length done", {done, desc_valid}, 2'b10);
      return;
    end
    while (r > 0) begin
      int el;
      int ec;
      int off;
      if (!en) begin
        ec = 4'b0111; el = r;
      end else begin
        off = a % lb;
        if (off != 0) begin
          ec = 4'b0111; el = (r < lb - off) ? r : lb - off;
        end else if (r >= lb) begin
          ec = 4'b1111; el = (r / lb) * lb;
        end else begin
          ec = 4'b0111; el = r;
        end
      end
      steps++;
      if (steps % 3 == 1) begin
        logic [3:0] c0;
        logic [ADDR_W-1:0] a0;
        logic [LEN_W-1:0] l0;
        desc_ready = 1'b0;
        req_valid = 1'b1;
        req_addr  = 32'hdead_0000;
        req_len   = 16'h0003;
        c0 = desc_cmd; a0 = desc_addr; l0 = desc_len;
        chk(req_ready == 1'b0, "R8 busy refuses request", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        req_cls   = CLS_W'(steps);
        chk(desc_valid && desc_cmd == c0 && desc_addr == a0 && desc_len == l0,
            "R7 stalled descriptor stable", {desc_cmd, desc_len}, {c0, l0});
      end
      desc_ready = 1'b1;
      if (ec == 4'b1111)
        chk(desc_valid && desc_cmd == 4'(ec) && desc_addr == ADDR_W'(a) && desc_len == LEN_W'(el),
            "R4 line multiple invalidate", {desc_cmd, desc_addr, desc_len}, {4'(ec), ADDR_W'(a), LEN_W'(el)});
      else if (!en)
        chk(desc_valid && desc_cmd == 4'(ec) && desc_addr == ADDR_W'(a) && desc_len == LEN_W'(el),
            "R2 R10 cache off single write", {desc_cmd, desc_addr, desc_len}, {4'(ec), ADDR_W'(a), LEN_W'(el)});
      else if ((a % lb) != 0)
        chk(desc_valid && desc_cmd == 4'(ec) && desc_addr == ADDR_W'(a) && desc_len == LEN_W'(el),
            "R3 unaligned head write", {desc_cmd, desc_addr, desc_len}, {4'(ec), ADDR_W'(a), LEN_W'(el)});
      else
        chk(desc_valid && desc_cmd == 4'(ec) && desc_addr == ADDR_W'(a) && desc_len == LEN_W'(el),
            "R5 tail write", {desc_cmd, desc_addr, desc_len}, {4'(ec), ADDR_W'(a), LEN_W'(el)});
      sum += int'(desc_len);
      a += el;
      r -= el;
      @(negedge clk);
      desc_ready = 1'b0;
    end
    chk(sum == len, "R6 lengths sum", sum, len);
    chk(done == 1'b1 && req_ready == 1'b1 && desc_valid == 1'b0, "R8 done after last",
        {done, req_ready, desc_valid}, 3'b110);
  endtask

  initial begin
    #(10 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cls_set[7] = '{0, 1, 2, 3, 4, 8, 16};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && desc_valid == 1'b0 && done == 1'b0, "R1 reset state",
        {req_ready, desc_valid, done}, 3'b100);
    for (int ci = 0; ci < 7; ci++) begin
      for (int oi = 0; oi < 20; oi++) begin
        for (int li = 0; li < 23; li++) begin
          xfers++;
          if (xfers % 4 == 0) begin
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", done, 0);
          end
          run_xfer(cls_set[ci], 32'h1000 + oi * 7, li * 5);
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b0 && desc_valid == 1'b0, "R8 idle at end", {done, desc_valid}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule